// File: doc/BRIEF.md
# Watchdog Timer with Guarded Configuration

This block is a watchdog timer whose settings sit in one 8-bit control/status register. A counter advances once per clock while the watchdog is active. When it reaches the selected time-out length, the block raises an interrupt, requests a system reset, or does the first and then the second. The mode comes from two register bits and from a fuse input. Software restarts the count with a clear strobe ("kick"). The interrupt controller acknowledges a taken interrupt with an acknowledge pulse.

The settings that matter most for safety are the reset enable and the time-out select. They can be weakened only inside a short window. Writing the change-enable bit opens that window for four clock cycles. A sticky reset-cause flag, driven from outside, holds the reset enable on. A programmed fuse forces reset mode no matter what the register holds.

Top module: `wdog_guard`

## Requirements
- R1: After reset the register reads 0x00, irqOut and rstReq are low, and the watchdog is stopped.
- R2: The time-out length is 2^(BASE_SHIFT+code) clock cycles. The 4-bit code is made of register bit 5 (its MSB) and bits 2..0. Codes 10 to 15 act as code 9.
- R3: Bit 6 enables the interrupt and bit 7 is the interrupt flag. In interrupt-only mode (bit 3 = 0, bit 6 = 1, fuse 1), a time-out sets the flag one cycle after the terminal count. irqOut is flag AND enable. An acknowledge clears only the flag.
- R4: Writing 1 to bit 7 clears the flag. Writing 0 to bit 7 leaves it as it is.
- R5: In reset-only mode (bit 3 = 1, bit 6 = 0), each time-out gives a one-cycle rstReq pulse. The pulse appears in the cycle after the terminal count.
- R6: Writing 1 to bit 4 (change enable) makes it read 1 for four cycles. It then clears by itself.
- R7: A write while the change enable is low cannot clear bit 3 and cannot change the time-out code. Setting bit 3 and writing bits 6 and 4 are always accepted.
- R8: In combined mode (bits 3 and 6 both 1), the first time-out sets the interrupt flag. If the flag is still set at the next time-out, rstReq pulses instead. An acknowledge clears both the flag and bit 6, which leaves the block in reset-only mode.
- R9: While rstFlag is high, bit 3 reads 1 and cannot be cleared, even inside the window. Once rstFlag falls, bit 3 stays 1 until it is cleared inside a window.
- R10: With fuseN low, every time-out pulses rstReq, whatever bits 3 and 6 hold, and irqOut stays low.
- R11: A kick restarts the count from zero. A kick in the same cycle as the terminal count wins, and that time-out does not happen.
- R12: When stopped (bits 3 and 6 both 0, rstFlag low, fuse 1), the counter is held at zero and neither output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read value |
| kick | input | 1 | Watchdog clear strobe |
| irqAck | input | 1 | Interrupt taken acknowledge |
| rstFlag | input | 1 | Sticky watchdog reset-cause flag |
| fuseN | input | 1 | Fuse, 0 = programmed (forced reset mode) |
| irqOut | output | 1 | Interrupt request |
| rstReq | output | 1 | System reset request pulse |

## Verification
Two events can land in the same cycle: a kick and the terminal count. In that case the kick must win, so no reset is produced. The bench applies the kick so that it is sampled on exactly the edge where the time-out would fire. It then expects the next reset one full period later, counted from that edge. The scoreboard compares the exact cycle of every interrupt and reset against the expected event list, so a time-out that slips through, or arrives early or late, shows up as a mismatch.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W  = 8;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic run;
    logic clear;
  } cntCmd_t;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_IRQ  = 2'd1,
    MODE_RST  = 2'd2,
    MODE_BOTH = 2'd3
  } wdMode_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_SHIFT = 11,
  parameter int NUM_STEPS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntCmd_t           cmd,
  input  logic [CODE_W-1:0] code,
  output logic              tmoHit
);
  localparam int CNT_W = BASE_SHIFT + NUM_STEPS;
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_STEPS - 1);

  logic [CNT_W-1:0]  count;
  logic [CODE_W-1:0] effCode;
  logic [CNT_W-1:0]  lastVal;

  always_comb begin
    effCode = (code > MAX_CODE) ? MAX_CODE : code;
    lastVal = (CNT_W'(1) << (BASE_SHIFT + int'(effCode))) - CNT_W'(1);
    tmoHit  = cmd.run && !cmd.clear && (count == lastVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (!cmd.run || cmd.clear || tmoHit) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(1);
    end
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> (count == '0));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              kick,
  input  logic              irqAck,
  input  logic              rstFlag,
  input  logic              fuseN,
  input  logic              tmoHit,
  output cntCmd_t           cmd,
  output logic [CODE_W-1:0] prescale,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqOut,
  output logic              rstReq
);
  localparam int WIN_W = $clog2(WIN_LEN) + 1;

  logic             irqFlag, irqEn, chgEn, rstEnReg;
  logic [WIN_W-1:0] winCnt;
  logic             rstEnEff, ackTaken, tmoIrq, tmoRst;
  wdMode_t          mode;

  always_comb begin
    rstEnEff = rstEnReg || rstFlag;
    if (!fuseN)                      mode = MODE_RST;
    else if (rstEnEff && irqEn)      mode = MODE_BOTH;
    else if (rstEnEff)               mode = MODE_RST;
    else if (irqEn)                  mode = MODE_IRQ;
    else                             mode = MODE_STOP;
    cmd.run   = (mode != MODE_STOP);
    cmd.clear = kick;
    irqOut    = irqFlag && irqEn && fuseN;
    ackTaken  = irqAck && irqOut;
    tmoIrq    = tmoHit && ((mode == MODE_IRQ) || ((mode == MODE_BOTH) && !irqFlag));
    tmoRst    = tmoHit && ((mode == MODE_RST) || ((mode == MODE_BOTH) && irqFlag));
    regRdData = {irqFlag, irqEn, prescale[3], chgEn, rstEnEff, prescale[2:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag  <= 1'b0;
      irqEn    <= 1'b0;
      chgEn    <= 1'b0;
      rstEnReg <= 1'b0;
      winCnt   <= '0;
      prescale <= '0;
      rstReq   <= 1'b0;
    end else begin
      rstReq <= tmoRst;

      if (regWrEn) begin
        chgEn  <= regWrData[4];
        winCnt <= WIN_W'(WIN_LEN - 1);
      end else if (chgEn) begin
        if (winCnt == '0) chgEn <= 1'b0;
        else              winCnt <= winCnt - WIN_W'(1);
      end

      if (regWrEn)
        rstEnReg <= (chgEn ? regWrData[3] : (rstEnReg || regWrData[3])) || rstFlag;
      else
        rstEnReg <= rstEnReg || rstFlag;

      if (regWrEn && chgEn)
        prescale <= {regWrData[5], regWrData[2:0]};

      if (ackTaken && (mode == MODE_BOTH)) irqEn <= 1'b0;
      else if (regWrEn)                    irqEn <= regWrData[6];

      if (tmoIrq)                                   irqFlag <= 1'b1;
      else if (ackTaken || (regWrEn && regWrData[7])) irqFlag <= 1'b0;
    end
  end

  logic [WIN_W-1:0] openAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            openAge <= '0;
    else if (regWrEn && regWrData[4])     openAge <= '0;
    else if (chgEn)                       openAge <= openAge + WIN_W'(1);
    else                                  openAge <= '0;
  end

  // R6
  window_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    chgEn |-> (openAge < WIN_W'(WIN_LEN)));

  // R7
  code_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !chgEn) |=> $stable(prescale));

  // R7
  rst_en_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chgEn && rstEnEff) |=> rstEnEff);

  // R9
  flag_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstFlag |=> rstEnReg);

  // R8
  unserviced_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_BOTH) && tmoHit && irqFlag) |=> rstReq);

  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_SHIFT = 11,
  parameter int NUM_STEPS  = 10,
  parameter int WIN_LEN    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             kick,
  input  logic             irqAck,
  input  logic             rstFlag,
  input  logic             fuseN,
  output logic             irqOut,
  output logic             rstReq
);
  cntCmd_t           cmd;
  logic [CODE_W-1:0] prescale;
  logic              tmoHit;

  wdog_ctrl #(.WIN_LEN(WIN_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .kick(kick), .irqAck(irqAck), .rstFlag(rstFlag), .fuseN(fuseN),
    .tmoHit(tmoHit), .cmd(cmd), .prescale(prescale),
    .regRdData(regRdData), .irqOut(irqOut), .rstReq(rstReq)
  );

  wdog_count #(.BASE_SHIFT(BASE_SHIFT), .NUM_STEPS(NUM_STEPS)) count_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .code(prescale), .tmoHit(tmoHit)
  );
endmodule

// File: tb/wdog_guard_tb_top.sv
`timescale 1ns/1ps
module wdog_guard_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic kick = 1'b0, irqAck = 1'b0, rstFlag = 1'b0, fuseN = 1'b1;
  logic irqOut, rstReq;

  always #2 clk = ~clk;

  wdog_guard #(.BASE_SHIFT(4)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .kick(kick), .irqAck(irqAck), .rstFlag(rstFlag),
    .fuseN(fuseN), .irqOut(irqOut), .rstReq(rstReq)
  );

  localparam int K_IRQ = 0;
  localparam int K_RST = 1;

  typedef struct {
    int    kind;
    int    at;
    string req;
  } evt_t;

  evt_t expQ[$];
  int compared = 0, mismatched = 0, evtCount = 0;
  int cyc = 0, wEdge = 0;
  logic prevIrq = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expEvt(input int kind, input int at, input string req);
    evt_t e;
    e.kind = kind; e.at = at; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic handleEvt(input int kind);
    evt_t e;
    evtCount++;
    compared++;
    if (expQ.size() == 0) begin
      mismatched++;
      $display("FAIL unexpected event: actual kind %0d at %0d expected none", kind, cyc);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        mismatched++;
        $display("FAIL %s: actual kind %0d at %0d expected kind %0d at %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (rstReq) handleEvt(K_RST);
      if (irqOut && !prevIrq) handleEvt(K_IRQ);
    end
    prevIrq <= irqOut;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    wEdge = cyc;
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    int c;
    int seen;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1
    chk("R1 reg", regRdData, 8'h00);
    chk("R1 irq", irqOut, 0);
    chk("R1 rst", rstReq, 0);
    seen = evtCount;
    waitCyc(40);
    chk("R12 stopped after reset", evtCount, seen);

    // R3: interrupt-only, code 0 -> 16 cycles
    wrReg(8'h40);
    expEvt(K_IRQ, wEdge + 16, "R3 irq timing");
    waitCyc(18);
    chk("R3 flag set", regRdData, 8'hC0);
    pulseAck();
    chk("R3 ack irqOut", irqOut, 0);
    chk("R3 ack keeps enable", regRdData, 8'h40);
    wrReg(8'h00);

    // R5, R7: reset-only mode and locked clear
    wrReg(8'h08);
    chk("R7 set rst enable unlocked", regRdData, 8'h08);
    expEvt(K_RST, wEdge + 16, "R5 reset timing");
    waitCyc(18);
    wrReg(8'h00);
    chk("R7 clear refused", regRdData, 8'h08);
    wrReg(8'h18);
    wrReg(8'h00);
    chk("R7 clear in window", regRdData, 8'h00);

    // R6: window expiry; R7 code lock
    wrReg(8'h18);
    c = wEdge;
    expEvt(K_RST, c + 16, "R5 reset timing 2");
    waitCyc(3);
    chk("R6 window open 4th cycle", regRdData, 8'h18);
    waitCyc(1);
    chk("R6 window closed", regRdData, 8'h08);
    wrReg(8'h01);
    chk("R7 code change refused", regRdData, 8'h08);
    waitCyc(12);
    wrReg(8'h18);
    wrReg(8'h00);

    // R2: code 1 -> 32 cycles; R4 write-one-clear
    wrReg(8'h10);
    wrReg(8'h41);
    chk("R2 code 1 accepted", regRdData, 8'h41);
    expEvt(K_IRQ, wEdge + 32, "R2 code 1 length");
    waitCyc(34);
    wrReg(8'hC1);
    chk("R4 w1c irqOut", irqOut, 0);
    chk("R4 w1c reg", regRdData, 8'h41);
    wrReg(8'h01);
    chk("R7 code kept on locked write", regRdData, 8'h01);

    // R2: reserved code 12 acts as code 9 (bit 5 is code MSB)
    wrReg(8'h10);
    wrReg(8'h64);
    expEvt(K_IRQ, wEdge + 8192, "R2 reserved code length");
    waitCyc(8194);
    pulseAck();
    chk("R3 ack irq-only", regRdData, 8'h64);
    wrReg(8'h00);

    // R8: combined mode
    wrReg(8'h10);
    wrReg(8'h48);
    c = wEdge;
    expEvt(K_IRQ, c + 16, "R8 first irq");
    expEvt(K_RST, c + 32, "R8 unserviced reset");
    waitCyc(34);
    pulseAck();
    chk("R8 downgrade reg", regRdData, 8'h08);
    chk("R8 downgrade irqOut", irqOut, 0);
    expEvt(K_RST, c + 48, "R8 reset-only after ack");
    waitCyc(14);
    wrReg(8'h18);
    wrReg(8'h00);

    // R11: kick coinciding with terminal count
    wrReg(8'h08);
    c = wEdge;
    waitCyc(15);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    expEvt(K_RST, c + 32, "R11 kick wins over time-out");
    waitCyc(18);
    wrReg(8'h18);
    wrReg(8'h00);

    // R9: sticky flag override
    @(negedge clk);
    rstFlag = 1'b1;
    c = cyc;
    expEvt(K_RST, c + 16, "R9 flag forces reset");
    wrReg(8'h18);
    wrReg(8'h00);
    chk("R9 clear refused with flag", regRdData, 8'h08);
    rstFlag = 1'b0;
    waitCyc(1);
    chk("R9 latched after flag drop", regRdData, 8'h08);
    waitCyc(16);
    wrReg(8'h18);
    wrReg(8'h00);
    chk("R9 cleared in window", regRdData, 8'h00);

    // R10: fuse forces reset mode
    @(negedge clk);
    fuseN = 1'b0;
    c = cyc;
    expEvt(K_RST, c + 16, "R10 fuse reset");
    wrReg(8'h40);
    waitCyc(16);
    chk("R10 irqOut low", irqOut, 0);
    chk("R10 flag not set", regRdData, 8'h40);
    wrReg(8'h00);
    fuseN = 1'b1;

    seen = evtCount;
    waitCyc(40);
    chk("R12 stopped at end", evtCount, seen);
    while (expQ.size() > 0) begin
      evt_t e;
      e = expQ.pop_front();
      compared++;
      mismatched++;
      $display("FAIL %s: actual missing expected kind %0d at %0d", e.req, e.kind, e.at);
    end
    finishRun();
  end
endmodule